// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Register Bank

This block holds the routing map of a twelve-output crosspoint switch. Every output is driven by a 4-bit code that names the input channel feeding it. The twelve codes come straight from a bank of active registers. A simple register bus can write these registers directly, and the new routing takes effect right away.

Two further banks hold staged routing maps. A whole staged map can be committed into the active bank in a single clock. There are three ways to trigger the commit:
- a software strobe bit in a control register;
- the level of an external protection-select pin, which picks between the two staged maps;
- a falling edge on that same pin.

Protection switching uses this arrangement. The working map and the standby map are loaded in advance, and the pin flips between them without any bus traffic.

The register bus is a plain single-cycle port with no back-pressure. A write is accepted on every clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The select outputs are plain level signals with no handshake.

Top module: `xpt_route_regs`

## Requirements
- R1: After reset, all three banks hold the default map and the control registers at 03h and 05h read 00h. In the default map:
  - outputs 0–3 select inputs 4–7;
  - outputs 4–7 select inputs 0–3;
  - outputs 8–11 select inputs 8–11.
- R2: Active register 0Dh−k holds the codes for outputs 2k (bits [3:0]) and 2k+1 (bits [7:4]). The code for output n appears on `xp_sel[4n+3:4n]`.
- R3: A bus write to an active register changes its two output codes on `xp_sel` from the clock edge that accepts the write. No strobe is needed.
- R4: Staged bank 1 sits at 13h−k and staged bank 2 at 19h−k, with the same per-register layout as the active bank. Writing them leaves `xp_sel` unchanged.
- R5: Writing 05h with bit 0 set copies a staged bank into the active bank at that edge. Bit 7 of the written byte picks the bank: 0 selects bank 1, 1 selects bank 2.
- R6: Bit 3 of 03h enables hardware strobing. While it is 0, the pin has no effect on the map.
- R7: Level mode applies when hardware strobing is enabled and bit 6 of 05h is 0. The active map follows bank 1 while the synchronized pin is high and bank 2 while it is low. It updates on the third clock edge after the pin changes.
- R8: Edge mode applies when hardware strobing is enabled and bit 6 of 05h is 1. Only a high-to-low pin transition commits, copying the bank chosen by the stored bit 7 of 05h, on the third edge after the pin falls. Rising edges and steady levels do nothing.
- R9: Every commit replaces all twelve codes at the same edge. The map never changes without a bus write or an enabled pin.
- R10: Bit 0 of 05h always reads 0. All other bits of 03h and 05h read back as written.
- R11: Reads of any bank register return its stored contents. Any address outside 03h, 05h and 08h–19h reads 00h.
- R12: Commit precedence is as follows:
  - level mode commits every cycle, overriding direct active writes and software strobes;
  - in edge mode, a pin falling edge takes precedence over a software strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| prot_pin | input | 1 | Asynchronous protection-select pin |
| xp_sel | output | 48 | Twelve 4-bit input-select codes, output n at bits [4n+3:4n] |

## Verification
Each result has a fixed timing relative to its stimulus:
- Read data is due in the same cycle the address is presented.
- A direct write or a software strobe shows on `xp_sel` one edge after the bus cycle.
- A pin change reaches the map on the third edge after it is applied: two synchronizer flops, then the commit register.

Inputs are driven on falling edges and results are sampled at the following falling edge. Pin tests check the full map after the second edge, where it must be unchanged, and again after the third edge, where the whole map must have switched at once. This pins down both the latency and the atomicity of the commit.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // Fixed register addresses whose positions other logic decodes
  localparam int unsigned XPT_ADR_HWCFG  = 'h03;
  localparam int unsigned XPT_ADR_STROBE = 'h05;
  localparam int unsigned XPT_ADR_ACTIVE = 'h08;

  // Control bit positions
  localparam int unsigned XPT_BIT_HW_EN = 3;
  localparam int unsigned XPT_BIT_SWSTB = 0;
  localparam int unsigned XPT_BIT_EDGE  = 6;
  localparam int unsigned XPT_BIT_BANK  = 7;

  // Lanes per switching group for the power-up map
  localparam int unsigned XPT_GRP_LANES = 4;

  // Power-up source for an output: groups 0 and 1 swapped, others straight
  function automatic int xpt_dflt_src(input int o);
    int g;
    int r;
    g = o / XPT_GRP_LANES;
    r = o % XPT_GRP_LANES;
    if (g == 0) return XPT_GRP_LANES + r;
    if (g == 1) return r;
    return o;
  endfunction
endpackage

// File: rtl/xpt_pin_sync.sv
module xpt_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/xpt_pair_bank.sv
module xpt_pair_bank
  import xpt_pkg::*;
#(
  parameter int unsigned NUM_PAIR = 6,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE     = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [2*SEL_W-1:0]                  wdata,
  input  logic                                load_en,
  input  logic [NUM_PAIR-1:0][2*SEL_W-1:0]    load_val,
  output logic [NUM_PAIR-1:0][2*SEL_W-1:0]    regs_q,
  output logic [2*SEL_W-1:0]                  rd_o
);
  localparam int unsigned PW  = 2 * SEL_W;
  localparam int unsigned TOP = BASE + NUM_PAIR - 1;

  // Register p lives at TOP-p: descending output order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAIR; p++) begin
        regs_q[p] <= {SEL_W'(xpt_dflt_src(2 * p + 1)), SEL_W'(xpt_dflt_src(2 * p))};
      end
    end else if (load_en) begin
      regs_q <= load_val;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PAIR; p++) begin
        if (addr == ADDR_W'(TOP - p)) regs_q[p] <= wdata;
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (addr == ADDR_W'(TOP - p)) rd_o = regs_q[p];
    end
  end

  logic unused_pw;
  assign unused_pw = (PW == 0);
endmodule

// File: rtl/xpt_route_regs.sv
module xpt_route_regs
  import xpt_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 12,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [2*SEL_W-1:0]         bus_wdata,
  output logic [2*SEL_W-1:0]         bus_rdata,
  input  logic                       prot_pin,
  output logic [NUM_OUT*SEL_W-1:0]   xp_sel
);
  localparam int unsigned NUM_PAIR = NUM_OUT / 2;
  localparam int unsigned PW       = 2 * SEL_W;
  localparam int unsigned STG1_BASE = XPT_ADR_ACTIVE + NUM_PAIR;
  localparam int unsigned STG2_BASE = XPT_ADR_ACTIVE + 2 * NUM_PAIR;

  logic [PW-1:0] hwcfg_q;
  logic [PW-1:0] strb_q;
  logic          hw_en, edge_mode, bank_sel;
  logic          pin_lvl, pin_fall;
  logic          sw_strobe, commit, commit_b2;
  logic [NUM_PAIR-1:0][PW-1:0] act_q, stg1_q, stg2_q, load_val;
  logic [PW-1:0] act_rd, stg1_rd, stg2_rd;

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwcfg_q <= '0;
      strb_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(XPT_ADR_HWCFG))  hwcfg_q <= bus_wdata;
      if (bus_addr == ADDR_W'(XPT_ADR_STROBE)) begin
        strb_q <= bus_wdata;
        strb_q[XPT_BIT_SWSTB] <= 1'b0;
      end
    end
  end

  assign hw_en     = hwcfg_q[XPT_BIT_HW_EN];
  assign edge_mode = strb_q[XPT_BIT_EDGE];
  assign bank_sel  = strb_q[XPT_BIT_BANK];
  assign sw_strobe = bus_wr && (bus_addr == ADDR_W'(XPT_ADR_STROBE))
                     && bus_wdata[XPT_BIT_SWSTB];

  xpt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (prot_pin),
    .lvl_o  (pin_lvl),
    .fall_o (pin_fall)
  );

  // Commit selection: level mode, then pin edge, then software strobe
  always_comb begin
    commit    = 1'b0;
    commit_b2 = 1'b0;
    if (hw_en && !edge_mode) begin
      commit    = 1'b1;
      commit_b2 = !pin_lvl;
    end else if (hw_en && pin_fall) begin
      commit    = 1'b1;
      commit_b2 = bank_sel;
    end else if (sw_strobe) begin
      commit    = 1'b1;
      commit_b2 = bus_wdata[XPT_BIT_BANK];
    end
  end

  assign load_val = commit_b2 ? stg2_q : stg1_q;

  xpt_pair_bank #(.NUM_PAIR(NUM_PAIR), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
                  .BASE(XPT_ADR_ACTIVE)) u_active (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .load_en(commit), .load_val(load_val), .regs_q(act_q), .rd_o(act_rd)
  );

  xpt_pair_bank #(.NUM_PAIR(NUM_PAIR), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
                  .BASE(STG1_BASE)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .load_en(1'b0), .load_val('0), .regs_q(stg1_q), .rd_o(stg1_rd)
  );

  xpt_pair_bank #(.NUM_PAIR(NUM_PAIR), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
                  .BASE(STG2_BASE)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .load_en(1'b0), .load_val('0), .regs_q(stg2_q), .rd_o(stg2_rd)
  );

  // Read mux: banks return zero outside their range
  always_comb begin
    bus_rdata = act_rd | stg1_rd | stg2_rd;
    if (bus_addr == ADDR_W'(XPT_ADR_HWCFG))  bus_rdata = hwcfg_q;
    if (bus_addr == ADDR_W'(XPT_ADR_STROBE)) bus_rdata = strb_q;
  end

  // Output n: register n/2, low nibble for even n
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign xp_sel[o*SEL_W +: SEL_W] = act_q[o/2][(o%2)*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/xpt_route_checker.sv
module xpt_route_checker #(
  parameter int unsigned NUM_PAIR = 6,
  parameter int unsigned PW       = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [PW-1:0]           bus_wdata,
  input logic [PW-1:0]           bus_rdata,
  input logic [NUM_PAIR*PW-1:0]  act_q,
  input logic [NUM_PAIR*PW-1:0]  stg1_q,
  input logic [NUM_PAIR*PW-1:0]  stg2_q,
  input logic                    hw_en,
  input logic                    edge_mode,
  input logic                    bank_sel,
  input logic                    pin_lvl,
  input logic                    pin_fall
);
  localparam int unsigned ACT_LO = 'h08;
  localparam int unsigned ACT_HI = ACT_LO + NUM_PAIR - 1;
  localparam int unsigned MAP_HI = ACT_LO + 3 * NUM_PAIR - 1;

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'('h03)) || (bus_addr == ADDR_W'('h05)) ||
                  ((bus_addr >= ADDR_W'(ACT_LO)) && (bus_addr <= ADDR_W'(MAP_HI)));

  // R3: direct write reaches the active register without a strobe
  assert_direct_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(ACT_HI) && !hw_en)
      |=> act_q[PW-1:0] == $past(bus_wdata));

  // R5: software strobe copies the bank named by the written bit 7
  assert_sw_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h05) && bus_wdata[0] && !hw_en)
      |=> act_q == $past(bus_wdata[7] ? stg2_q : stg1_q));

  // R7: level mode follows bank 1 high, bank 2 low
  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !edge_mode)
      |=> act_q == $past(pin_lvl ? stg1_q : stg2_q));

  // R8: a falling pin in edge mode copies the stored bank choice
  assert_edge_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && edge_mode && pin_fall)
      |=> act_q == $past(bank_sel ? stg2_q : stg1_q));

  // R9: no bus write and no pin control means the map holds
  assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !hw_en) |=> $stable(act_q));

  // R10: strobe bit always reads zero
  assert_strobe_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h05)) |-> !bus_rdata[0]);

  // R11: unmapped addresses read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);
endmodule

bind xpt_route_regs xpt_route_checker #(
  .NUM_PAIR(NUM_OUT / 2), .PW(2 * SEL_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_q(act_q),
  .stg1_q(stg1_q), .stg2_q(stg2_q), .hw_en(hw_en), .edge_mode(edge_mode),
  .bank_sel(bank_sel), .pin_lvl(pin_lvl), .pin_fall(pin_fall)
);

// File: tb/xpt_route_regs_tb_top.sv
module xpt_route_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        prot_pin = 1'b0;
  logic [47:0] xp_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  xpt_route_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_pin(prot_pin),
    .xp_sel(xp_sel)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] waddr;
    logic [7:0] wdata;
    logic [7:0] raddr;
    logic [7:0] exp_rd;
    logic [3:0] oidx;
    logic [3:0] exp_out;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 8'h00, 8'h0D, 8'h54, 4'd0,  4'h4}, // R1 R2 default pair 0
    '{1'b0, 8'h00, 8'h00, 8'h08, 8'hBA, 4'd11, 4'hB}, // R1 R2 default pair 5
    '{1'b1, 8'h0D, 8'h3A, 8'h0D, 8'h3A, 4'd0,  4'hA}, // R3 direct write
    '{1'b0, 8'h00, 8'h00, 8'h0D, 8'h3A, 4'd1,  4'h3}, // R2 odd output high nibble
    '{1'b1, 8'h13, 8'h21, 8'h13, 8'h21, 4'd0,  4'hA}, // R4 stage1 write, map kept
    '{1'b1, 8'h19, 8'h65, 8'h19, 8'h65, 4'd1,  4'h3}, // R4 stage2 write, map kept
    '{1'b1, 8'h0E, 8'h01, 8'h0E, 8'h01, 4'd10, 4'hA}, // R4 stage1 last register
    '{1'b1, 8'h05, 8'h01, 8'h0D, 8'h21, 4'd10, 4'h1}, // R5 strobe bank 1
    '{1'b1, 8'h05, 8'h81, 8'h0D, 8'h65, 4'd10, 4'hA}, // R5 strobe bank 2
    '{1'b0, 8'h00, 8'h00, 8'h05, 8'h80, 4'd0,  4'h5}, // R10 strobe bit reads 0
    '{1'b1, 8'h03, 8'h52, 8'h03, 8'h52, 4'd0,  4'h5}, // R10 readback of 03h
    '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1,  4'h6}, // R11 unmapped 00h
    '{1'b0, 8'h00, 8'h00, 8'h1A, 8'h00, 4'd11, 4'hB}, // R11 unmapped 1Ah
    '{1'b0, 8'h00, 8'h00, 8'h04, 8'h00, 4'd7,  4'h3}, // R11 unmapped 04h
    '{1'b1, 8'h0A, 8'hC7, 8'h0A, 8'hC7, 4'd6,  4'h7}  // R3 direct write pair 3
  };

  function automatic logic [47:0] mk_map(input logic [7:0] p5, p4, p3, p2, p1, p0);
    return {p5, p4, p3, p2, p1, p0};
  endfunction

  localparam logic [47:0] DFLT  = {8'hBA, 8'h98, 8'h32, 8'h10, 8'h76, 8'h54};
  localparam logic [47:0] BANK1 = {8'h01, 8'h98, 8'h32, 8'h10, 8'h76, 8'h21};
  localparam logic [47:0] BANK2 = {8'hBA, 8'h98, 8'h32, 8'h10, 8'h76, 8'h65};

  task automatic check(input string what, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input string what, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1ns;
    check(what, {40'd0, bus_rdata}, {40'd0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 map after reset", xp_sel, DFLT);
    read_check("R1 03h after reset", 8'h03, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].waddr, VECS[i].wdata);
      else @(negedge clk);
      read_check($sformatf("table row %0d read", i), VECS[i].raddr, VECS[i].exp_rd);
      check($sformatf("table row %0d output %0d", i, VECS[i].oidx),
            {44'd0, xp_sel[VECS[i].oidx*4 +: 4]}, {44'd0, VECS[i].exp_out});
    end

    // R6: pin ignored while hardware strobing is off
    @(negedge clk) prot_pin = 1'b1;
    repeat (5) @(negedge clk);
    prot_pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 pin ignored", xp_sel, mk_map(8'hBA, 8'h98, 8'hC7, 8'h10, 8'h76, 8'h65));

    // R7: level mode, pin low selects bank 2
    bus_write(8'h05, 8'h00);
    bus_write(8'h03, 8'h08);
    @(negedge clk);
    check("R7 level low -> bank 2", xp_sel, BANK2);
    prot_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 level not yet at edge 2", xp_sel, BANK2);
    @(negedge clk);
    check("R7 level high -> bank 1 at edge 3", xp_sel, BANK1);

    // R12: level mode overrides a direct active write
    bus_write(8'h0D, 8'hFF);
    read_check("R12 level overrides write read", 8'h0D, 8'h21);
    check("R12 level overrides write map", xp_sel, BANK1);

    // R8: edge mode, bank 2 chosen by stored bit 7
    bus_write(8'h05, 8'hC0);
    prot_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 map unchanged before edge commit", xp_sel, BANK1);
    @(negedge clk);
    check("R8 fall commits bank 2", xp_sel, BANK2);
    bus_write(8'h0D, 8'hEE);
    check("R3 direct write in edge mode", {44'd0, xp_sel[3:0]}, 48'hE);
    prot_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 rising edge ignored", xp_sel,
          mk_map(8'hBA, 8'h98, 8'h32, 8'h10, 8'h76, 8'hEE));
    bus_write(8'h05, 8'h40);
    prot_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 whole map held before commit", xp_sel,
          mk_map(8'hBA, 8'h98, 8'h32, 8'h10, 8'h76, 8'hEE));
    @(negedge clk);
    check("R9 whole map switched at one edge", xp_sel, BANK1);
    check("R8 fall commits bank 1", {44'd0, xp_sel[3:0]}, 48'h1);

    // R1: reset in mid-run restores defaults
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 map after second reset", xp_sel, DFLT);
    read_check("R1 05h after reset", 8'h05, 8'h00);
    read_check("R1 stage1 after reset", 8'h13, 8'h54);
    read_check("R1 stage2 after reset", 8'h14, 8'hBA);

    finish_run();
  end
endmodule